// File: doc/BRIEF.md
# Channel Address and Chaining Unit

This block keeps the word address and the remaining word count of one I/O channel. Software first alerts the channel for an interlace load, which zeroes both registers. It then supplies an interlace control word that fills in the low fourteen address bits and the low ten count bits. A later mode word fills in the high address and count bits and leaves the low parts as they are. A separate six-bit chain word names a page to jump to and says whether the jump should raise an interrupt. Loading the chain word leaves a chain pending.

Every accepted word transfer (the step strobe) adds one to the address and subtracts one from the count. When the new address lands on the first word of a 2048-word page and a chain is pending, the address is instead sent to the first word of the chained page. The pending chain is then used up, and a one-cycle zero-count interrupt pulse is raised if the chain word asked for one. A readback request returns the current address one cycle later.

A small state machine tracks the interlace. It has three states:
- `ST_IDLE`: after reset, with the interlace off.
- `ST_WAIT`: entered on an alert, waiting for the interlace word.
- `ST_ACTIVE`: entered whenever an interlace word is loaded.

The transitions are:
- `ALERT`: any state goes to `ST_WAIT`.
- `LOAD`: any state goes to `ST_ACTIVE`. This transition takes priority over `ALERT`.
- `HOLD`: the state is kept when neither strobe is present.

Steps are honoured only in `ST_ACTIVE`.

Top module: `chan_addr_chain`

## Requirements
- R1: After synchronous reset the address, the count, the chain-pending flag, the interlace flag, the interrupt pulse and the readback valid are all 0.
- R2: An interlace load puts word bits 23:14 into count bits 9:0 and word bits 13:0 into address bits 13:0. It keeps the higher address and count bits and sets the interlace flag.
- R3: A mode load puts its 2-bit high address into address bits 15:14 and its 5-bit high count into count bits 14:10. It keeps the lower bits.
- R4: An alert clears the address and the count to 0 and drops the interlace flag. An alert together with an interlace load clears the high parts and loads the low parts.
- R5: A step while the interlace flag is set adds 1 to the address (modulo 2^16) and subtracts 1 from the count (modulo 2^15, so 0 becomes 0x7FFF).
- R6: A step has no effect on the address or the count while the interlace flag is clear. It also has no effect in a cycle that carries an alert, an interlace load or a mode load.
- R7: A chain load stores the 6-bit chain word and sets chain-pending. Bit 5 of the word enables the interrupt and bits 4:0 give the page.
- R8: If a step's incremented address has bits 10:0 equal to zero while chain-pending is set, the address becomes {page, 11'b0} and chain-pending clears. The interrupt output pulses high for exactly one cycle if chain bit 5 is set.
- R9: Without a pending chain, a page crossing is a plain increment and raises no interrupt.
- R10: When a chain load and a chaining step fall in the same cycle, the jump uses the old chain word. Chain-pending stays set, now holding the new word.
- R11: A readback request gives, in the next cycle, the valid flag high and the address as it stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alert_i | input | 1 | Alert for interlace load; zeroes address and count |
| ilc_load_i | input | 1 | Interlace word load strobe |
| ilc_word_i | input | 24 | Interlace word: count low in 23:14, address low in 13:0 |
| mode_load_i | input | 1 | Mode word load strobe |
| mode_hi_addr_i | input | 2 | High address bits 15:14 |
| mode_hi_cnt_i | input | 5 | High count bits 14:10 |
| chain_load_i | input | 1 | Chain word load strobe |
| chain_word_i | input | 6 | Bit 5 interrupt enable, bits 4:0 page |
| step_i | input | 1 | One word transferred |
| rd_req_i | input | 1 | Address readback request |
| addr_o | output | 16 | Current address |
| count_o | output | 15 | Current word count |
| ilce_o | output | 1 | Interlace active |
| chain_pend_o | output | 1 | Chain pending |
| zc_irq_o | output | 1 | One-cycle zero-count interrupt pulse from chaining |
| rd_valid_o | output | 1 | Readback data valid |
| rd_addr_o | output | 16 | Readback address |

## Verification
A chain load can arrive in the same cycle as a step that crosses a page while an older chain is pending. The bench forces this overlap by arming page 1 and then, at address 0x0FFF, driving a step together with a new chain word for page 7. It judges the result by a jump to 0x0800 with an interrupt and chain-pending still set. A second page crossing then has to land at 0x3800. A readback request is also issued in the same cycle as a step, and the returned value must be the address from before the step.

// File: rtl/chan_pkg.sv
package chan_pkg;
    localparam int PA_W   = 16;
    localparam int OFF_W  = 11;
    localparam int LO_A_W = 14;
    localparam int CNT_W  = 15;
    localparam int LO_C_W = 10;
    localparam int PN_W   = PA_W - OFF_W;
    localparam int DCR_W  = PN_W + 1;
    localparam int HI_A_W = PA_W - LO_A_W;
    localparam int HI_C_W = CNT_W - LO_C_W;
    localparam int ILC_W  = LO_C_W + LO_A_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } ilc_state_t;
endpackage

// File: rtl/chan_fsm.sv
module chan_fsm
    import chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alert,
    input  logic ilc_load,
    output logic ilce
);
    ilc_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT, ST_ACTIVE: begin
                if (ilc_load)   state_d = ST_ACTIVE;
                else if (alert) state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ilce = 1'b0;
        unique case (state_q)
            ST_ACTIVE: ilce = 1'b1;
            ST_IDLE, ST_WAIT: ilce = 1'b0;
            default: ilce = 1'b0;
        endcase
    end
endmodule

// File: rtl/chan_chain_reg.sv
module chan_chain_reg
    import chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DCR_W-1:0] word,
    input  logic             consume,
    output logic [DCR_W-1:0] dcr,
    output logic             pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dcr  <= '0;
            pend <= 1'b0;
        end else begin
            if (load) dcr <= word;
            if (load)         pend <= 1'b1;
            else if (consume) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_step.sv
module chan_step
    import chan_pkg::*;
(
    input  logic [PA_W-1:0]  addr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             pend,
    input  logic [DCR_W-1:0] dcr,
    output logic [PA_W-1:0]  next_addr,
    output logic [CNT_W-1:0] next_cnt,
    output logic             jump,
    output logic             irq_req
);
    logic [PA_W-1:0] inc;

    always_comb begin
        inc       = addr + 1'b1;
        next_cnt  = cnt - 1'b1;
        jump      = pend && (inc[OFF_W-1:0] == '0);
        irq_req   = jump && dcr[DCR_W-1];
        next_addr = jump ? {dcr[PN_W-1:0], {OFF_W{1'b0}}} : inc;
    end
endmodule

// File: rtl/chan_readback.sv
module chan_readback
    import chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [PA_W-1:0] addr,
    output logic            valid,
    output logic [PA_W-1:0] data
);
    localparam logic [PA_W-1:0] PA_MASK = {PA_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= req;
            if (req) data <= addr & PA_MASK;
        end
    end
endmodule

// File: rtl/chan_addr_chain.sv
module chan_addr_chain
    import chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alert_i,
    input  logic              ilc_load_i,
    input  logic [ILC_W-1:0]  ilc_word_i,
    input  logic              mode_load_i,
    input  logic [HI_A_W-1:0] mode_hi_addr_i,
    input  logic [HI_C_W-1:0] mode_hi_cnt_i,
    input  logic              chain_load_i,
    input  logic [DCR_W-1:0]  chain_word_i,
    input  logic              step_i,
    input  logic              rd_req_i,
    output logic [PA_W-1:0]   addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ilce_o,
    output logic              chain_pend_o,
    output logic              zc_irq_o,
    output logic              rd_valid_o,
    output logic [PA_W-1:0]   rd_addr_o
);
    logic [PA_W-1:0]  addr_q, addr_d, step_addr;
    logic [CNT_W-1:0] cnt_q, cnt_d, step_cnt;
    logic [DCR_W-1:0] dcr;
    logic             pend, ilce, jump, irq_req, step_ok, irq_q;

    chan_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .alert    (alert_i),
        .ilc_load (ilc_load_i),
        .ilce     (ilce)
    );

    chan_chain_reg u_chain (
        .clk     (clk),
        .rst     (rst),
        .load    (chain_load_i),
        .word    (chain_word_i),
        .consume (step_ok && jump),
        .dcr     (dcr),
        .pend    (pend)
    );

    chan_step u_step (
        .addr      (addr_q),
        .cnt       (cnt_q),
        .pend      (pend),
        .dcr       (dcr),
        .next_addr (step_addr),
        .next_cnt  (step_cnt),
        .jump      (jump),
        .irq_req   (irq_req)
    );

    chan_readback u_rb (
        .clk   (clk),
        .rst   (rst),
        .req   (rd_req_i),
        .addr  (addr_q),
        .valid (rd_valid_o),
        .data  (rd_addr_o)
    );

    assign step_ok = step_i && ilce && !(alert_i || ilc_load_i || mode_load_i);

    always_comb begin
        addr_d = addr_q;
        cnt_d  = cnt_q;
        if (alert_i) begin
            addr_d = '0;
            cnt_d  = '0;
        end
        if (ilc_load_i) begin
            addr_d[LO_A_W-1:0] = ilc_word_i[LO_A_W-1:0];
            cnt_d[LO_C_W-1:0]  = ilc_word_i[ILC_W-1:LO_A_W];
        end
        if (mode_load_i) begin
            addr_d[PA_W-1:LO_A_W] = mode_hi_addr_i;
            cnt_d[CNT_W-1:LO_C_W] = mode_hi_cnt_i;
        end
        if (step_ok) begin
            addr_d = step_addr;
            cnt_d  = step_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            addr_q <= addr_d;
            cnt_q  <= cnt_d;
            irq_q  <= step_ok && irq_req;
        end
    end

    assign addr_o       = addr_q;
    assign count_o      = cnt_q;
    assign ilce_o       = ilce;
    assign chain_pend_o = pend;
    assign zc_irq_o     = irq_q;
endmodule

// File: rtl/chan_addr_chain_chk.sv
module chan_addr_chain_chk
    import chan_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             alert_i,
    input logic             ilc_load_i,
    input logic             mode_load_i,
    input logic             chain_load_i,
    input logic             step_i,
    input logic             rd_req_i,
    input logic [PA_W-1:0]  addr_o,
    input logic [CNT_W-1:0] count_o,
    input logic             ilce_o,
    input logic             chain_pend_o,
    input logic             zc_irq_o,
    input logic             rd_valid_o,
    input logic [PA_W-1:0]  rd_addr_o
);
    logic quiet;
    assign quiet = !(alert_i || ilc_load_i || mode_load_i);

    p_count_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (step_i && ilce_o && quiet) |=> (count_o == ($past(count_o) - 15'd1)));

    p_step_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (step_i && !ilce_o && quiet) |=> ($stable(addr_o) && $stable(count_o)));

    p_alert_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (alert_i && !ilc_load_i && !mode_load_i) |=> (addr_o == '0 && count_o == '0 && !ilce_o));

    p_ilce_set_r2: assert property (@(posedge clk) disable iff (rst)
        ilc_load_i |=> ilce_o);

    p_chain_set_r7: assert property (@(posedge clk) disable iff (rst)
        chain_load_i |=> chain_pend_o);

    p_irq_needs_chain_r8: assert property (@(posedge clk) disable iff (rst)
        zc_irq_o |-> $past(chain_pend_o));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        zc_irq_o |=> !zc_irq_o);

    p_readback_r11: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> (rd_valid_o && rd_addr_o == $past(addr_o)));
endmodule

bind chan_addr_chain chan_addr_chain_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .alert_i      (alert_i),
    .ilc_load_i   (ilc_load_i),
    .mode_load_i  (mode_load_i),
    .chain_load_i (chain_load_i),
    .step_i       (step_i),
    .rd_req_i     (rd_req_i),
    .addr_o       (addr_o),
    .count_o      (count_o),
    .ilce_o       (ilce_o),
    .chain_pend_o (chain_pend_o),
    .zc_irq_o     (zc_irq_o),
    .rd_valid_o   (rd_valid_o),
    .rd_addr_o    (rd_addr_o)
);

// File: tb/chan_addr_chain_tb.sv
module chan_addr_chain_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alert_i = 0, ilc_load_i = 0, mode_load_i = 0, chain_load_i = 0;
    logic        step_i = 0, rd_req_i = 0;
    logic [23:0] ilc_word_i = '0;
    logic [1:0]  mode_hi_addr_i = '0;
    logic [4:0]  mode_hi_cnt_i = '0;
    logic [5:0]  chain_word_i = '0;
    logic [15:0] addr_o, rd_addr_o;
    logic [14:0] count_o;
    logic        ilce_o, chain_pend_o, zc_irq_o, rd_valid_o;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    chan_addr_chain u_dut (
        .clk(clk), .rst(rst), .alert_i(alert_i), .ilc_load_i(ilc_load_i),
        .ilc_word_i(ilc_word_i), .mode_load_i(mode_load_i),
        .mode_hi_addr_i(mode_hi_addr_i), .mode_hi_cnt_i(mode_hi_cnt_i),
        .chain_load_i(chain_load_i), .chain_word_i(chain_word_i),
        .step_i(step_i), .rd_req_i(rd_req_i), .addr_o(addr_o),
        .count_o(count_o), .ilce_o(ilce_o), .chain_pend_o(chain_pend_o),
        .zc_irq_o(zc_irq_o), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
        alert_i = 0; ilc_load_i = 0; mode_load_i = 0; chain_load_i = 0;
        step_i = 0; rd_req_i = 0;
    endtask

    function automatic logic [23:0] ilc(input logic [9:0] c, input logic [13:0] a);
        return {c, a};
    endfunction

    task automatic t_reset();
        rst = 1; tick(); tick(); rst = 0;
        check("R1 addr", addr_o, 0);
        check("R1 count", count_o, 0);
        check("R1 flags", {ilce_o, chain_pend_o, zc_irq_o, rd_valid_o}, 0);
    endtask

    task automatic t_ilc_mode();
        ilc_load_i = 1; ilc_word_i = ilc(10'h2A5, 14'h1234); tick();
        check("R2 addr", addr_o, 16'h1234);
        check("R2 count", count_o, 15'h02A5);
        check("R2 ilce", ilce_o, 1);
        mode_load_i = 1; mode_hi_addr_i = 2'b10; mode_hi_cnt_i = 5'h13; tick();
        check("R3 addr", addr_o, 16'h9234);
        check("R3 count", count_o, 15'h4EA5);
        ilc_load_i = 1; ilc_word_i = ilc(10'h001, 14'h0005); tick();
        check("R2 keep high addr", addr_o, 16'h8005);
        check("R2 keep high count", count_o, 15'h4C01);
    endtask

    task automatic t_step_alert();
        step_i = 1; tick();
        check("R5 addr", addr_o, 16'h8006);
        check("R5 count", count_o, 15'h4C00);
        alert_i = 1; tick();
        check("R4 addr", addr_o, 0);
        check("R4 count", count_o, 0);
        check("R4 ilce", ilce_o, 0);
        step_i = 1; tick();
        check("R6 idle step addr", addr_o, 0);
        check("R6 idle step count", count_o, 0);
    endtask

    task automatic t_wrap_plain_cross();
        ilc_load_i = 1; ilc_word_i = ilc(10'h000, 14'h07FF); tick();
        step_i = 1; tick();
        check("R9 addr", addr_o, 16'h0800);
        check("R5 count wrap", count_o, 15'h7FFF);
        check("R9 no irq", zc_irq_o, 0);
        step_i = 1; mode_load_i = 1; mode_hi_addr_i = 2'b01; mode_hi_cnt_i = 5'h00; tick();
        check("R6 step with mode addr", addr_o, 16'h4800);
        check("R6 step with mode count", count_o, 15'h03FF);
    endtask

    task automatic t_chain_irq();
        chain_load_i = 1; chain_word_i = 6'h2C; tick();
        check("R7 pend", chain_pend_o, 1);
        alert_i = 1; ilc_load_i = 1; ilc_word_i = ilc(10'h005, 14'h27FE); tick();
        check("R4 alert+ilc addr", addr_o, 16'h27FE);
        check("R4 alert+ilc count", count_o, 15'h0005);
        step_i = 1; tick();
        check("R8 pre addr", addr_o, 16'h27FF);
        check("R8 pre irq", zc_irq_o, 0);
        step_i = 1; tick();
        check("R8 jump addr", addr_o, 16'h6000);
        check("R8 irq", zc_irq_o, 1);
        check("R8 pend clr", chain_pend_o, 0);
        check("R5 count", count_o, 15'h0003);
        tick();
        check("R8 irq one cycle", zc_irq_o, 0);
    endtask

    task automatic t_chain_quiet();
        chain_load_i = 1; chain_word_i = 6'h03; tick();
        ilc_load_i = 1; ilc_word_i = ilc(10'h010, 14'h07FF); tick();
        check("R2 setup addr", addr_o, 16'h47FF);
        step_i = 1; tick();
        check("R8 quiet jump addr", addr_o, 16'h1800);
        check("R8 quiet no irq", zc_irq_o, 0);
        check("R8 quiet pend clr", chain_pend_o, 0);
    endtask

    task automatic t_collide();
        chain_load_i = 1; chain_word_i = 6'h21; tick();
        ilc_load_i = 1; ilc_word_i = ilc(10'h010, 14'h0FFF); tick();
        step_i = 1; chain_load_i = 1; chain_word_i = 6'h27; tick();
        check("R10 old page", addr_o, 16'h0800);
        check("R10 irq", zc_irq_o, 1);
        check("R10 pend kept", chain_pend_o, 1);
        step_i = 1; tick();
        check("R10 next plain", addr_o, 16'h0801);
        ilc_load_i = 1; ilc_word_i = ilc(10'h010, 14'h0FFF); tick();
        step_i = 1; tick();
        check("R10 new page", addr_o, 16'h3800);
        check("R10 new irq", zc_irq_o, 1);
    endtask

    task automatic t_readback();
        rd_req_i = 1; step_i = 1; tick();
        check("R11 valid", rd_valid_o, 1);
        check("R11 data", rd_addr_o, 16'h3800);
        check("R11 addr moved", addr_o, 16'h3801);
        tick();
        check("R11 valid drops", rd_valid_o, 0);
    endtask

    initial begin
        #5;
        t_reset();
        t_ilc_mode();
        t_step_alert();
        t_wrap_plain_cross();
        t_chain_irq();
        t_chain_quiet();
        t_collide();
        t_readback();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule